// File: doc/BRIEF.md
# DDR Read Latency Strobe Sequencer

This block is a synthesizable, cycle-level model of the read output timing of a double-data-rate memory. A small mode register holds the burst length, the burst ordering and the CAS latency. It is written through a mode-load request that carries address and bank bits, and it is guarded so that only legal loads, made at legal times, change it. After a registered READ command, the block produces the strobe output-enable, the strobe level and a data-valid pattern. These appear after the programmed latency and carry two words per clock for the programmed burst length.

The design is single-clock. Each output that would change on both clock edges is a two-bit vector. Bit 0 is the half-clock that follows the rising edge and bit 1 is the half-clock that follows the falling edge. Preamble and postamble are therefore whole half-clock phases. The memory array is replaced by a generator: each data word is the column address of its beat, zero-extended to the word width. This makes the ordering directly visible.

Top module: `rdq_seq`

## Requirements
- R1: The 7-bit mode value `modeQ` resets to 0x32 and holds a load's `mrsAddr[6:0]`. Bits [2:0] encode the burst length (001=2, 010=4, 011=8). Bit [3] selects interleaved ordering (1) or sequential ordering (0). Bits [6:4] encode the latency (010=2, 011=3).
- R2: A load with a nonzero `mrsBank` or any nonzero bit in `mrsAddr[13:7]` does not target the mode register. It is ignored and raises no flag.
- R3: A targeted load while `allIdle` is low leaves `modeQ` unchanged. It raises `mrsIllegal` for exactly the one cycle after that edge.
- R4: A targeted, legally timed load whose burst-length code or latency code is reserved leaves `modeQ` unchanged. It raises `cfgErr` for the one cycle after that edge.
- R5: `dpdReq` returns `modeQ` to 0x32 at the next edge. A load presented at the same edge is discarded and raises no flag.
- R6: For a READ accepted at edge n, the first data pair is valid in the cycle after edge n+1 at latency 2, and in the cycle after edge n+2 at latency 3.
- R7: A burst of length BL keeps `dqValid` at 11 for exactly BL/2 consecutive cycles. Outside those cycles `dqValid` is 00.
- R8: Beat i of a burst starting at column c addresses column (c with its low log2(BL) bits replaced by x). Here x = (c+i) mod BL for sequential ordering and x = (c xor i) mod BL for interleaved ordering. Beat 2p is on `dqWord0` and beat 2p+1 is on `dqWord1` in data cycle p.
- R9: In the cycle before the first data pair, `dqsOe`=11 and `dqsLvl`=00 (preamble). Every data cycle has `dqsOe`=11 and `dqsLvl`=01. The cycle after the last data pair has `dqsOe`=01 and `dqsLvl`=00 (half-clock postamble). The following cycle returns to 00.
- R10: A READ registered while a burst is waiting, in preamble or in data raises `rdCollide` for one cycle. It is ignored, and the running burst continues unchanged. A READ registered in the postamble cycle is accepted.
- R11: A READ registered at the same edge as an accepted load uses the mode value held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mrsLoad | input | 1 | Mode-load request |
| mrsAddr | input | 14 | Address bits of the mode load |
| mrsBank | input | 2 | Bank bits of the mode load |
| allIdle | input | 1 | High when all banks are idle |
| dpdReq | input | 1 | Deep power-down entry |
| readCmd | input | 1 | READ command |
| readCol | input | 10 | Starting column of the READ |
| modeQ | output | 7 | Current mode value |
| mrsIllegal | output | 1 | Load attempted while banks busy |
| cfgErr | output | 1 | Load carried a reserved code |
| rdCollide | output | 1 | READ arrived during a burst |
| dqsOe | output | 2 | Strobe output-enable per half-clock |
| dqsLvl | output | 2 | Strobe level per half-clock |
| dqValid | output | 2 | Data valid per half-clock |
| dqWord0 | output | 32 | Word of the rising-edge half |
| dqWord1 | output | 32 | Word of the falling-edge half |

## Verification
Two functions can fall on the same edge: a mode load and a READ. The bench presents both together and checks that the burst runs with the old latency, length and ordering, while `modeQ` shows the new value afterwards. A second collision is a second READ that lands on the last data edge or on the postamble edge of a running burst. The first case must be rejected with the running burst intact on the data ports. The second must start a new burst directly after the postamble. Deep power-down and a load on the same edge form a third pairing, judged by `modeQ` and by the absence of flags.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  localparam int PAIR_W = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_PRE,
    PH_DATA,
    PH_POST
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    phaseT             phase;
    logic [PAIR_W-1:0] pairIdx;
    logic [1:0]        blLog;
    logic              ilv;
    logic              capture;
  } ctlT;
endpackage

// File: rtl/rdq_ctrl.sv
module rdq_ctrl
  import rdq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2,
  parameter int MODE_W = 7,
  parameter logic [MODE_W-1:0] MODE_RST = 7'h32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsLoad,
  input  logic [ADDR_W-1:0] mrsAddr,
  input  logic [BANK_W-1:0] mrsBank,
  input  logic              allIdle,
  input  logic              dpdReq,
  input  logic              readCmd,
  output logic [MODE_W-1:0] modeQ,
  output logic              mrsIllegal,
  output logic              cfgErr,
  output logic              rdCollide,
  output ctlT               ctl
);
  localparam int ILV_BIT = 3;
  localparam int CL_LSB  = 4;

  function automatic logic blOk(input logic [2:0] code);
    return code inside {3'b001, 3'b010, 3'b011};
  endfunction

  function automatic logic clOk(input logic [2:0] code);
    return code inside {3'b010, 3'b011};
  endfunction

  logic [MODE_W-1:0] modeR;
  logic targeted, codeGood, doLoad, badState, badCode;
  logic busy, accept;
  phaseT phase;
  logic [PAIR_W-1:0] pairIdx, lastPair;
  logic [1:0] blLogR, curBlLog;
  logic ilvR;

  always_comb begin
    targeted = mrsLoad && (mrsBank == '0) && (mrsAddr[ADDR_W-1:MODE_W] == '0);
    codeGood = blOk(mrsAddr[2:0]) && clOk(mrsAddr[CL_LSB+2:CL_LSB]);
    doLoad   = targeted && !dpdReq && allIdle && codeGood;
    badState = targeted && !dpdReq && !allIdle;
    badCode  = targeted && !dpdReq && allIdle && !codeGood;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR      <= MODE_RST;
      mrsIllegal <= 1'b0;
      cfgErr     <= 1'b0;
    end else begin
      if (dpdReq)      modeR <= MODE_RST;
      else if (doLoad) modeR <= mrsAddr[MODE_W-1:0];
      mrsIllegal <= badState;
      cfgErr     <= badCode;
    end
  end

  always_comb begin
    busy   = phase inside {PH_WAIT, PH_PRE, PH_DATA};
    accept = readCmd && !busy;
    unique case (modeR[2:0])
      3'b001:  curBlLog = 2'd1;
      3'b011:  curBlLog = 2'd3;
      default: curBlLog = 2'd2;
    endcase
    unique case (blLogR)
      2'd1:    lastPair = PAIR_W'(0);
      2'd3:    lastPair = PAIR_W'(3);
      default: lastPair = PAIR_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      pairIdx   <= '0;
      blLogR    <= 2'd2;
      ilvR      <= 1'b0;
      rdCollide <= 1'b0;
    end else begin
      rdCollide <= readCmd && busy;
      if (accept) begin
        phase   <= (modeR[CL_LSB+2:CL_LSB] == 3'b011) ? PH_WAIT : PH_PRE;
        pairIdx <= '0;
        blLogR  <= curBlLog;
        ilvR    <= modeR[ILV_BIT];
      end else begin
        unique case (phase)
          PH_WAIT: phase <= PH_PRE;
          PH_PRE:  begin phase <= PH_DATA; pairIdx <= '0; end
          PH_DATA: begin
            if (pairIdx == lastPair) phase <= PH_POST;
            else pairIdx <= pairIdx + 1'b1;
          end
          PH_POST: phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    modeQ       = modeR;
    ctl.phase   = phase;
    ctl.pairIdx = pairIdx;
    ctl.blLog   = blLogR;
    ctl.ilv     = ilvR;
    ctl.capture = accept;
  end
endmodule

// File: rtl/rdq_dpath.sv
module rdq_dpath
  import rdq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [COL_W-1:0]  readCol,
  output logic [1:0]        dqsOe,
  output logic [1:0]        dqsLvl,
  output logic [1:0]        dqValid,
  output logic [DATA_W-1:0] dqWord0,
  output logic [DATA_W-1:0] dqWord1
);
  localparam int BEATS = 2;

  logic [COL_W-1:0] startCol, blkMask;
  logic [BEATS-1:0][DATA_W-1:0] beatWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            startCol <= '0;
    else if (ctl.capture) startCol <= readCol;
  end

  always_comb blkMask = ({{(COL_W-1){1'b0}}, 1'b1} << ctl.blLog) - 1'b1;

  for (genvar gb = 0; gb < BEATS; gb++) begin : g_beat
    logic [COL_W-1:0] bIdx, offs, col;
    always_comb begin
      bIdx = COL_W'({ctl.pairIdx, 1'(gb)});
      offs = ctl.ilv ? (startCol ^ bIdx) : (startCol + bIdx);
      col  = (startCol & ~blkMask) | (offs & blkMask);
    end
    assign beatWord[gb] = DATA_W'(col);
  end

  always_comb begin
    dqsOe   = 2'b00;
    dqsLvl  = 2'b00;
    dqValid = 2'b00;
    dqWord0 = '0;
    dqWord1 = '0;
    unique case (ctl.phase)
      PH_PRE:  dqsOe = 2'b11;
      PH_DATA: begin
        dqsOe   = 2'b11;
        dqsLvl  = 2'b01;
        dqValid = 2'b11;
        dqWord0 = beatWord[0];
        dqWord1 = beatWord[1];
      end
      PH_POST: dqsOe = 2'b01;
      default: ;
    endcase
  end
endmodule

// File: rtl/rdq_seq.sv
module rdq_seq
  import rdq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 2,
  parameter int MODE_W = 7,
  parameter int COL_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mrsLoad,
  input  logic [ADDR_W-1:0] mrsAddr,
  input  logic [BANK_W-1:0] mrsBank,
  input  logic              allIdle,
  input  logic              dpdReq,
  input  logic              readCmd,
  input  logic [COL_W-1:0]  readCol,
  output logic [MODE_W-1:0] modeQ,
  output logic              mrsIllegal,
  output logic              cfgErr,
  output logic              rdCollide,
  output logic [1:0]        dqsOe,
  output logic [1:0]        dqsLvl,
  output logic [1:0]        dqValid,
  output logic [DATA_W-1:0] dqWord0,
  output logic [DATA_W-1:0] dqWord1
);
  ctlT ctl;

  rdq_ctrl #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mrsLoad(mrsLoad), .mrsAddr(mrsAddr),
    .mrsBank(mrsBank), .allIdle(allIdle), .dpdReq(dpdReq),
    .readCmd(readCmd), .modeQ(modeQ), .mrsIllegal(mrsIllegal),
    .cfgErr(cfgErr), .rdCollide(rdCollide), .ctl(ctl)
  );

  rdq_dpath #(.COL_W(COL_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .readCol(readCol),
    .dqsOe(dqsOe), .dqsLvl(dqsLvl), .dqValid(dqValid),
    .dqWord0(dqWord0), .dqWord1(dqWord1)
  );
endmodule

// File: rtl/rdq_seq_chk.sv
module rdq_seq_chk #(
  parameter int MODE_W = 7,
  parameter logic [MODE_W-1:0] MODE_RST = 7'h32
) (
  input logic              clk,
  input logic              rstN,
  input logic              mrsLoad,
  input logic              allIdle,
  input logic              dpdReq,
  input logic              readCmd,
  input logic [MODE_W-1:0] modeQ,
  input logic              mrsIllegal,
  input logic              cfgErr,
  input logic              rdCollide,
  input logic [1:0]        dqsOe,
  input logic [1:0]        dqsLvl,
  input logic [1:0]        dqValid
);
  // R3
  illegal_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    mrsIllegal |-> $past(mrsLoad) && !$past(allIdle));
  // R3
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mrsIllegal |-> $stable(modeQ));
  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $stable(modeQ));
  // R5
  dpd_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(dpdReq) |-> modeQ == MODE_RST);
  // R7
  pair_whole_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqValid == 2'b00 || dqValid == 2'b11);
  // R9
  data_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqValid != 2'b00 |-> dqsOe == 2'b11 && dqsLvl == 2'b01);
  // R9
  postamble_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqValid[0]) |-> dqsOe == 2'b01 && dqsLvl == 2'b00);
  // R10
  collide_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdCollide |-> $past(readCmd));
endmodule

bind rdq_seq rdq_seq_chk u_chk (.*);

// File: tb/rdq_seq_bench.sv
module rdq_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mrsLoad = 1'b0;
  logic [13:0] mrsAddr = '0;
  logic [1:0]  mrsBank = '0;
  logic        allIdle = 1'b1;
  logic        dpdReq = 1'b0;
  logic        readCmd = 1'b0;
  logic [9:0]  readCol = '0;
  logic [6:0]  modeQ;
  logic        mrsIllegal, cfgErr, rdCollide;
  logic [1:0]  dqsOe, dqsLvl, dqValid;
  logic [31:0] dqWord0, dqWord1;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rdq_seq u_rdq_seq (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] beatCol(input int c, input int i, input int bl, input bit ilv);
    int mask = bl - 1;
    int off = ilv ? ((c ^ i) & mask) : ((c + i) & mask);
    return 32'((c & ~mask) | off);
  endfunction

  task automatic loadMode(input logic [13:0] a, input logic [1:0] b, input bit idle,
                          input bit dpd, input logic [6:0] expMode,
                          input bit expIll, input bit expErr, input string req);
    mrsLoad = 1'b1; mrsAddr = a; mrsBank = b; allIdle = idle; dpdReq = dpd;
    step();
    mrsLoad = 1'b0; allIdle = 1'b1; dpdReq = 1'b0;
    check(req, {mrsIllegal, cfgErr, modeQ}, {expIll, expErr, expMode});
    step();
    check(req, {mrsIllegal, cfgErr, modeQ}, {1'b0, 1'b0, expMode});
  endtask

  // checks a burst cycle by cycle; extraAt >= 0 drives a second READ after cycle extraAt
  task automatic runRead(input int col, input int cl, input int bl, input bit ilv,
                         input bit issue, input int extraAt, input int extraCol, input string req);
    int kpost = cl - 1 + bl / 2;
    int kend = (extraAt == kpost) ? kpost : kpost + 1;
    if (issue) begin readCmd = 1'b1; readCol = 10'(col); end
    step();
    readCmd = 1'b0; mrsLoad = 1'b0;
    for (int k = 0; k <= kend; k++) begin
      logic [1:0] eOe = 2'b00, eLvl = 2'b00, eVal = 2'b00;
      logic [31:0] eW0 = '0, eW1 = '0;
      bit eCol = (extraAt >= 0) && (extraAt < kpost) && (k == extraAt + 1);
      if (k == cl - 2) eOe = 2'b11;
      else if (k >= cl - 1 && k < kpost) begin
        int p = k - (cl - 1);
        eOe = 2'b11; eLvl = 2'b01; eVal = 2'b11;
        eW0 = beatCol(col, 2 * p, bl, ilv);
        eW1 = beatCol(col, 2 * p + 1, bl, ilv);
      end else if (k == kpost) eOe = 2'b01;
      check(req, {rdCollide, dqsOe, dqsLvl, dqValid, dqWord0, dqWord1},
                 {eCol, eOe, eLvl, eVal, eW0, eW1});
      if (k == extraAt) begin readCmd = 1'b1; readCol = 10'(extraCol); end
      if (k == kend) break;
      step();
      readCmd = 1'b0;
    end
  endtask

  task automatic tReset();
    check("R1 reset mode", {mrsIllegal, cfgErr, rdCollide, modeQ}, {3'b000, 7'h32});
    check("R9 reset idle", {dqsOe, dqsLvl, dqValid}, 6'b0);
  endtask

  task automatic tDefaultRead();
    runRead(5, 3, 4, 1'b0, 1'b1, -1, 0, "R6 R7 R8 R9 cl3 bl4 seq");
  endtask

  task automatic tProgramModes();
    loadMode(14'h2B, 2'b00, 1'b1, 1'b0, 7'h2B, 1'b0, 1'b0, "R1 load bl8 ilv cl2");
    runRead(19, 2, 8, 1'b1, 1'b1, -1, 0, "R6 R7 R8 cl2 bl8 ilv");
    loadMode(14'h31, 2'b00, 1'b1, 1'b0, 7'h31, 1'b0, 1'b0, "R1 load bl2 seq cl3");
    runRead(7, 3, 2, 1'b0, 1'b1, -1, 0, "R7 R8 cl3 bl2");
    loadMode(14'h23, 2'b00, 1'b1, 1'b0, 7'h23, 1'b0, 1'b0, "R1 load bl8 seq cl2");
    runRead(13, 2, 8, 1'b0, 1'b1, -1, 0, "R8 cl2 bl8 seq wrap");
  endtask

  task automatic tNonTarget();
    loadMode(14'h32, 2'b01, 1'b1, 1'b0, 7'h23, 1'b0, 1'b0, "R2 bank bits set");
    loadMode(14'h0132, 2'b00, 1'b1, 1'b0, 7'h23, 1'b0, 1'b0, "R2 high address bit set");
  endtask

  task automatic tIllegal();
    loadMode(14'h2A, 2'b00, 1'b0, 1'b0, 7'h23, 1'b1, 1'b0, "R3 banks busy");
    runRead(2, 2, 8, 1'b0, 1'b1, -1, 0, "R3 mode unchanged after busy load");
  endtask

  task automatic tReserved();
    loadMode(14'h27, 2'b00, 1'b1, 1'b0, 7'h23, 1'b0, 1'b1, "R4 reserved burst code");
    loadMode(14'h12, 2'b00, 1'b1, 1'b0, 7'h23, 1'b0, 1'b1, "R4 reserved latency code");
  endtask

  task automatic tDeepPowerDown();
    loadMode(14'h2A, 2'b00, 1'b1, 1'b1, 7'h32, 1'b0, 1'b0, "R5 dpd beats load");
    runRead(6, 3, 4, 1'b0, 1'b1, -1, 0, "R5 default mode after dpd");
  endtask

  task automatic tCollide();
    runRead(9, 3, 4, 1'b0, 1'b1, 0, 100, "R10 read during wait");
    runRead(9, 3, 4, 1'b0, 1'b1, 3, 100, "R10 read on last data edge");
    runRead(9, 3, 4, 1'b0, 1'b1, 4, 22, "R10 read in postamble accepted");
    runRead(22, 3, 4, 1'b0, 1'b0, -1, 0, "R10 back-to-back second burst");
  endtask

  task automatic tLoadWithRead();
    mrsLoad = 1'b1; mrsAddr = 14'h2B; mrsBank = 2'b00; allIdle = 1'b1;
    runRead(10, 3, 4, 1'b0, 1'b1, -1, 0, "R11 read uses old mode");
    check("R11 new mode after", {mrsIllegal, cfgErr, modeQ}, {2'b00, 7'h2B});
    runRead(10, 2, 8, 1'b1, 1'b1, -1, 0, "R11 next read uses new mode");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();
    tReset();
    tDefaultRead();
    tProgramModes();
    tNonTarget();
    tIllegal();
    tReserved();
    tDeepPowerDown();
    tCollide();
    tLoadWithRead();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule